// File: doc/BRIEF.md
# Oscillator Warm-Up Counter

This block keeps the system waiting after an oscillator has been switched on, until enough oscillator edges have passed for the clock to be treated as stable. It counts down a programmable number of source-clock edges. The count is the 8-bit warm-up time multiplied by a divider ratio, and the source is either the fast or the slow oscillator. Each oscillator reaches the block as a one-cycle tick that has already been brought into the block's clock domain.

A warm-up can start in three ways. The hardware starts one on its own when reset is released, and while it runs a hold output keeps the rest of the chip in reset. The hardware also starts one when stop mode ends; this run counts on the oscillator that was driving the system when stop was entered, whatever the programmed source select says. Software starts one when it switches a second oscillator on, and only this kind of run raises an interrupt request when it completes. A time setting of zero is never counted: the start is refused and an error pulse is raised instead.

Top module: `osc_warmup`

## Requirements
- R1: While reset is applied and on the first cycle after it, `time_val` reads 0x66, `busy` is 0, `hold_rst` is 1, and `done`, `irq` and `err` are 0.
- R2: On the first clock edge after reset is released, a warm-up starts on its own. It counts fast ticks at the `div_sel` present on that edge. `hold_rst` stays 1 until that run completes, and it falls on the same edge as its `done`.
- R3: A run completes after exactly `time_val` × 4^`div_sel` ticks of its source, where `div_sel` 0..3 gives ratios 1, 4, 16 and 64. `done` goes high on the edge that takes the last counted tick, and `busy` goes low on that same edge. Ticks that arrive on the start edge are not counted.
- R4: A pulse on `start_sw` starts a run whose source is `src_sel` (0 = fast tick, 1 = slow tick). `irq` is high together with `done` when that run completes.
- R5: A pulse on `stop_wake` starts a run on the source named by `prev_src` (0 = fast, 1 = slow), whatever `src_sel` is. This run never raises `irq`.
- R6: If a start request arrives while `time_val` is 0x00, no run begins. `err` is high for exactly one cycle, and `busy` stays 0.
- R7: `start_sw` and `stop_wake` are ignored while `busy` is 1. The running count, its source and its completion are unchanged, and no second `done` follows.
- R8: A cycle with `time_wr` high loads `time_wdata` into the time register, and the new value appears on `time_val` one edge later.
- R9: `done`, `irq` and `err` are single-cycle pulses, and `irq` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_fast | input | 1 | One-cycle pulse per fast-oscillator edge |
| tick_slow | input | 1 | One-cycle pulse per slow-oscillator edge |
| src_sel | input | 1 | Source for software starts: 0 fast, 1 slow |
| div_sel | input | 2 | Divider ratio select, ratio = 4^div_sel |
| time_wr | input | 1 | Write strobe for the time register |
| time_wdata | input | 8 | Data for the time register |
| start_sw | input | 1 | Software start request |
| stop_wake | input | 1 | Stop-mode release start request |
| prev_src | input | 1 | Oscillator that was in use when stop was entered |
| time_val | output | 8 | Current warm-up time register |
| busy | output | 1 | A warm-up is counting |
| done | output | 1 | Completion strobe |
| irq | output | 1 | Interrupt request on completion of a software start |
| err | output | 1 | Start refused because the time setting is zero |
| hold_rst | output | 1 | Holds the system in reset until the power-up warm-up ends |

## Verification
The hardest situation to reach from the ports is a start request that lands while a run is already counting. A careless design would restart the count there or switch its source. The stimulus starts a fast run and, partway through, pulses a software start with a different source and divider. The scoreboard then requires that exactly one completion arrives, after the original number of fast ticks. The stop-release case is set up with `src_sel` and `prev_src` pointing at different oscillators, which run at different tick rates. A run that counts on the wrong source therefore completes after the wrong number of counted edges.

// File: rtl/wu_pkg.sv
// Shared types for the oscillator warm-up counter.
// Assumes the two oscillators arrive as synchronized one-cycle ticks.
package wu_pkg;
    typedef enum logic {SRC_FAST = 1'b0, SRC_SLOW = 1'b1} wu_src_e;
    typedef enum logic [1:0] {KIND_NONE, KIND_POR, KIND_STOP, KIND_SW} wu_kind_e;
endpackage

// File: rtl/wu_time_reg.sv
// Warm-up time register. It resets to a fixed non-zero value and is written with a strobe.
// Assumes the write data is stable while the strobe is high.
module wu_time_reg #(
    parameter int          TIME_W   = 8,
    parameter logic [TIME_W-1:0] TIME_RST = 8'h66
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [TIME_W-1:0] wdata,
    output logic [TIME_W-1:0] q
);
    // Hold the programmed warm-up time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= TIME_RST;
        else if (wr)
            q <= wdata;
    end
endmodule

// File: rtl/wu_start_arb.sv
// Start arbitration. It picks the start kind and the source oscillator, and it accepts
// or refuses the start. Priority is power-up, then stop release, then software.
// Assumes busy comes from the counter registers, so no combinational loop forms.
module wu_start_arb
    import wu_pkg::*;
#(
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              start_sw,
    input  logic              stop_wake,
    input  logic              src_sel,
    input  logic              prev_src,
    input  logic [TIME_W-1:0] time_val,
    output logic              go,
    output logic              refuse,
    output wu_kind_e          kind,
    output wu_src_e           src
);
    logic por_pend;
    logic req;

    // A power-up start is pending from reset until the first idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            por_pend <= 1'b1;
        else if (!busy)
            por_pend <= 1'b0;
    end

    // Pick the start kind and its source oscillator.
    always_comb begin
        kind = KIND_NONE;
        src  = SRC_FAST;
        if (por_pend) begin
            kind = KIND_POR;
            src  = SRC_FAST;
        end else if (stop_wake) begin
            kind = KIND_STOP;
            src  = wu_src_e'(prev_src);
        end else if (start_sw) begin
            kind = KIND_SW;
            src  = wu_src_e'(src_sel);
        end
    end

    // Accept the start when idle; refuse it when the time setting is zero.
    always_comb begin
        req    = (kind != KIND_NONE) && !busy;
        go     = req && (time_val != '0);
        refuse = req && (time_val == '0);
    end
endmodule

// File: rtl/wu_tick_mux.sv
// Source tick selector. It passes the tick of the oscillator the running warm-up latched.
// Assumes the ticks are synchronous, one-cycle pulses.
module wu_tick_mux
    import wu_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0] ticks,
    input  wu_src_e          sel,
    output logic             tick
);
    // Pick the tick of the selected source.
    always_comb tick = ticks[int'(sel)];
endmodule

// File: rtl/wu_down_cnt.sv
// Warm-up down-counter. It loads time x 4^div on a start and counts source ticks
// down to completion. It drives busy, done, irq, err and the power-up reset hold.
// Assumes go and refuse are never high together and are only high while idle.
module wu_down_cnt
    import wu_pkg::*;
#(
    parameter int TIME_W   = 8,
    parameter int DIV_W    = 2,
    parameter int DIV_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              refuse,
    input  wu_kind_e          kind,
    input  wu_src_e           src,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [TIME_W-1:0] time_val,
    input  logic              tick,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic              err,
    output logic              hold_rst,
    output wu_src_e           run_src
);
    localparam int CNT_W = TIME_W + DIV_STEP * ((1 << DIV_W) - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load;
    wu_kind_e         run_kind;

    // Terminal count: the time value shifted up by the divider exponent.
    always_comb load = CNT_W'(time_val) << (DIV_STEP * int'(div_sel));

    // Load on a start, count selected ticks, and pulse the completion outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            irq      <= 1'b0;
            err      <= 1'b0;
            hold_rst <= 1'b1;
            run_src  <= SRC_FAST;
            run_kind <= KIND_NONE;
        end else begin
            done <= 1'b0;
            irq  <= 1'b0;
            err  <= refuse;
            if (go) begin
                cnt      <= load;
                busy     <= 1'b1;
                run_src  <= src;
                run_kind <= kind;
            end else if (busy && tick) begin
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    irq  <= (run_kind == KIND_SW);
                    if (run_kind == KIND_POR)
                        hold_rst <= 1'b0;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
    a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
    a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r3_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt != '0));
    a_r2_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_rst) |-> done);
    a_r7_src_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(run_src));
endmodule

// File: rtl/osc_warmup.sv
// Oscillator warm-up counter top. It wires the time register, the start arbiter,
// the tick selector and the down-counter together.
// Assumes the ticks and all control inputs are synchronous to clk.
module osc_warmup
    import wu_pkg::*;
#(
    parameter int          TIME_W   = 8,
    parameter int          DIV_W    = 2,
    parameter int          DIV_STEP = 2,
    parameter logic [TIME_W-1:0] TIME_RST = 8'h66
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic              src_sel,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              time_wr,
    input  logic [TIME_W-1:0] time_wdata,
    input  logic              start_sw,
    input  logic              stop_wake,
    input  logic              prev_src,
    output logic [TIME_W-1:0] time_val,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic              err,
    output logic              hold_rst
);
    logic     go;
    logic     refuse;
    logic     tick;
    wu_kind_e kind;
    wu_src_e  src;
    wu_src_e  run_src;

    wu_time_reg #(.TIME_W(TIME_W), .TIME_RST(TIME_RST)) u_time (
        .clk(clk), .rst_n(rst_n), .wr(time_wr), .wdata(time_wdata), .q(time_val)
    );

    wu_start_arb #(.TIME_W(TIME_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .busy(busy), .start_sw(start_sw),
        .stop_wake(stop_wake), .src_sel(src_sel), .prev_src(prev_src),
        .time_val(time_val), .go(go), .refuse(refuse), .kind(kind), .src(src)
    );

    wu_tick_mux #(.N_SRC(2)) u_mux (
        .ticks({tick_slow, tick_fast}), .sel(run_src), .tick(tick)
    );

    wu_down_cnt #(.TIME_W(TIME_W), .DIV_W(DIV_W), .DIV_STEP(DIV_STEP)) u_cnt (
        .clk(clk), .rst_n(rst_n), .go(go), .refuse(refuse), .kind(kind),
        .src(src), .div_sel(div_sel), .time_val(time_val), .tick(tick),
        .busy(busy), .done(done), .irq(irq), .err(err), .hold_rst(hold_rst),
        .run_src(run_src)
    );
endmodule

// File: tb/sim_osc_warmup.sv
// Scoreboard bench: driver tasks queue the expected runs, and the monitor counts
// source ticks and checks each completion against the queue.
module sim_osc_warmup;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_fast = 1'b0, tick_slow = 1'b0;
    logic       src_sel = 1'b0, prev_src = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic       time_wr = 1'b0;
    logic [7:0] time_wdata = 8'h00;
    logic       start_sw = 1'b0, stop_wake = 1'b0;
    logic [7:0] time_val;
    logic       busy, done, irq, err, hold_rst;

    int total = 0, fails = 0, cyc = 0, tick_cnt = 0;
    // Expected item: {irq, src, count}
    typedef struct { bit irq; bit src; int n; } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    osc_warmup u0 (
        .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .src_sel(src_sel), .div_sel(div_sel), .time_wr(time_wr),
        .time_wdata(time_wdata), .start_sw(start_sw), .stop_wake(stop_wake),
        .prev_src(prev_src), .time_val(time_val), .busy(busy), .done(done),
        .irq(irq), .err(err), .hold_rst(hold_rst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Monitor: check completions, then drive the next ticks and count the selected one.
    always @(negedge clk) begin
        bit nf, ns;
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7 unexpected done", 1, 0);
            end else begin
                chk(tick_cnt == exp_q[0].n, "R3 tick count", tick_cnt, exp_q[0].n);
                chk(irq == exp_q[0].irq, "R4 irq on done", irq, exp_q[0].irq);
                void'(exp_q.pop_front());
            end
            tick_cnt = 0;
        end
        cyc++;
        nf = (cyc % 2 == 0);
        ns = (cyc % 7 == 0);
        tick_fast = nf;
        tick_slow = ns;
        if (rst_n && busy && exp_q.size() != 0)
            if (exp_q[0].src ? ns : nf) tick_cnt++;
    end

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    task automatic wait_idle();
        @(negedge clk);
        while (exp_q.size() != 0 || busy) @(negedge clk);
    endtask

    task automatic write_time(input logic [7:0] v);
        @(negedge clk); time_wr = 1'b1; time_wdata = v;
        @(negedge clk); time_wr = 1'b0;
        chk(time_val == v, "R8 time write", time_val, v);
    endtask

    task automatic sw_run(input bit s, input logic [1:0] d, input logic [7:0] t);
        write_time(t);
        src_sel = s; div_sel = d;
        exp_q.push_back('{irq: 1'b1, src: s, n: int'(t) << (2 * d)});
        start_sw = 1'b1;
        @(negedge clk); start_sw = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(time_val == 8'h66, "R1 reset time", time_val, 8'h66);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(hold_rst == 1'b1, "R1 reset hold", hold_rst, 1);
        chk(done == 1'b0 && irq == 1'b0 && err == 1'b0, "R1 reset pulses", done, 0);
        // R2: power-up run on fast ticks, 0x66 x 1
        exp_q.push_back('{irq: 1'b0, src: 1'b0, n: 8'h66});
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R2 auto start", busy, 1);
        chk(hold_rst == 1'b1, "R2 hold during run", hold_rst, 1);
        wait_idle();
        chk(hold_rst == 1'b0, "R2 hold released", hold_rst, 0);

        // R4: software run on the slow source, ratio 4
        sw_run(1'b1, 2'd1, 8'd3);
        // R3: fast source, ratio 16
        sw_run(1'b0, 2'd2, 8'd5);
        // R3: fast source, ratio 64
        sw_run(1'b0, 2'd3, 8'd2);

        // R7: a start during a run is ignored
        write_time(8'd10);
        src_sel = 1'b0; div_sel = 2'd1;
        exp_q.push_back('{irq: 1'b1, src: 1'b0, n: 40});
        start_sw = 1'b1; @(negedge clk); start_sw = 1'b0;
        repeat (6) @(negedge clk);
        src_sel = 1'b1; div_sel = 2'd3;
        start_sw = 1'b1; @(negedge clk); start_sw = 1'b0;
        stop_wake = 1'b1; @(negedge clk); stop_wake = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R7 no restart", busy, 0);

        // R5: stop release counts on prev_src, not src_sel, with no irq
        write_time(8'd2);
        src_sel = 1'b0; prev_src = 1'b1; div_sel = 2'd2;
        exp_q.push_back('{irq: 1'b0, src: 1'b1, n: 32});
        stop_wake = 1'b1; @(negedge clk); stop_wake = 1'b0;
        wait_idle();

        // R6: zero time refused on a software start
        write_time(8'd0);
        start_sw = 1'b1; @(negedge clk); start_sw = 1'b0;
        chk(err == 1'b1, "R6 err pulse", err, 1);
        chk(busy == 1'b0, "R6 no run", busy, 0);
        @(negedge clk);
        chk(err == 1'b0, "R9 err single cycle", err, 0);
        // R6: zero time refused on a stop release
        stop_wake = 1'b1; @(negedge clk); stop_wake = 1'b0;
        chk(err == 1'b1 && busy == 1'b0, "R6 stop zero refused", err, 1);
        repeat (10) @(negedge clk);
        chk(busy == 1'b0 && exp_q.size() == 0, "R6 stays idle", busy, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule